// File: doc/BRIEF.md
# Serial SAR Converter Readout Controller

This block is the master side of a three-wire link to a 12-bit successive-approximation converter: an active-low chip select, a serial clock, and a data line from the converter. One pulse on `start` opens one conversion frame. The controller pulls chip select low and waits one half period before the first serial clock edge. It then generates the serial clock from the system clock and gathers the result bits, most significant bit first. It returns a signed 12-bit sample with a one-cycle valid strobe.

The converter spends the first four serial clock cycles acquiring the input. It drives a new result bit after every falling edge from the fifth onward. The controller samples each bit half a period after the falling edge that launched it. A frame can be cut short after fewer result bits, which saves converter power. The bits received are then left-justified, the lower bits are zero-filled, and the bit count is reported with the sample. The serial clock half period can be set within the converter's legal band. Burst mode forces the fastest legal rate, so the trigger spacing alone sets the sample rate.

Top module: `serial_adc_reader`

## Requirements
- R1: A full frame (effective bit count 12) holds `adc_cs_n` low for exactly 33 half periods and produces exactly 16 rising edges of `adc_sclk`; in general a frame has 4 + N rising edges.
- R2: Result bit k (k = 0 is the MSB) is the value the converter drives after the (5 + k)-th falling edge of `adc_sclk` in the frame; it is sampled half a period after that edge.
- R3: Whatever the data line carries during the first four serial clock periods (the acquisition phase) has no effect on `sample_data`.
- R4: `sample_data` is 12-bit two's complement with the sign in bit 11: 0x7FF reads as +2047, 0x800 as -2048 and 0xFFF as -1.
- R5: `bit_count` N in 1..11 ends the frame early: `adc_cs_n` rises half a period after the N-th result bit's launching falling edge, so the frame lasts 9 + 2N half periods; values 0 and 12..15 select a full 12-bit frame.
- R6: A short frame places its N bits in `sample_data[11:12-N]`, clears the remaining lower bits, and reports N on `sample_bits`.
- R7: `adc_sclk` is low whenever `adc_cs_n` is high.
- R8: The first rising edge of `adc_sclk` comes exactly one half period after `adc_cs_n` falls and never on the same cycle.
- R9: The half period in system cycles is `half_div` clamped to [HALF_MIN, HALF_MAX] (16..39 at 250 MHz, covering 8 MHz down to 3.2 MHz); `burst` = 1 forces HALF_MIN. `half_div`, `burst` and `bit_count` are sampled only when a frame starts.
- R10: `busy` is high from the cycle after a start is accepted until the inter-frame gap ends; a `start` pulse while `busy` is high starts nothing and does not alter the frame in progress.
- R11: `sample_valid` pulses for exactly one cycle, in the cycle in which `adc_cs_n` returns high.
- R12: Between frames `adc_cs_n` stays high for 2*H + 1 system cycles when `start` is held high, H being the half period of the finished frame, so at least one full serial clock period separates frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion frame; accepted only while idle |
| burst | input | 1 | Force the fastest legal serial clock for the next frame |
| half_div | input | DIV_W | Requested serial clock half period in system cycles |
| bit_count | input | NB_W | Result bits to read (1..11 short, 0 or 12..15 full) |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter, idles low |
| busy | output | 1 | Frame or inter-frame gap in progress |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_data | output | RES_BITS | Signed, left-justified result |
| sample_bits | output | NB_W | Number of result bits in this sample |

## Verification
The assertions take for granted that CLK_HZ gives a minimum half period of at least two system cycles. The guard check depends on this, because it treats a rising edge in the cycle right after chip select falls as an error. They also take for granted that `rst_n` is low at time zero, so the edge-detect registers start at their idle values. The stimulus applies every input at the falling edge of the system clock and changes `half_div`, `burst` and `bit_count` only while no frame is running, except in the one frame that deliberately disturbs them. The converter model changes the data line only on falling serial clock edges, and during acquisition it toggles the line, so any sampling that slips by one half period shows up as a wrong result.

// File: rtl/serial_adc_reader.sv
`timescale 1ns/1ps
module serial_adc_reader #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int MIN_SCLK_HZ = 3_200_000,
  parameter int MAX_SCLK_HZ = 8_000_000,
  parameter int RES_BITS    = 12,
  parameter int LEAD_FALLS  = 4,
  parameter int DIV_W       = 8,
  parameter int NB_W        = $clog2(RES_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                burst,
  input  logic [DIV_W-1:0]    half_div,
  input  logic [NB_W-1:0]     bit_count,
  input  logic                adc_dout,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                busy,
  output logic                sample_valid,
  output logic [RES_BITS-1:0] sample_data,
  output logic [NB_W-1:0]     sample_bits
);

  localparam int HALF_MIN     = (CLK_HZ + 2*MAX_SCLK_HZ - 1) / (2*MAX_SCLK_HZ);
  localparam int HALF_MAX     = CLK_HZ / (2*MIN_SCLK_HZ);
  localparam int LAST_HALF    = 2*(LEAD_FALLS + RES_BITS) + 1;
  localparam int IDX_W        = $clog2(LAST_HALF + 1);
  localparam int FIRST_SAMPLE = 2*LEAD_FALLS + 3;
  localparam int CNT_W        = DIV_W + 1;
  localparam int BP_W         = $clog2(RES_BITS);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_GAP} state_t;

  state_t               state;
  logic [DIV_W-1:0]     half_len;
  logic [CNT_W-1:0]     cnt;
  logic [IDX_W-1:0]     hidx, end_idx;
  logic [BP_W-1:0]      bpos;
  logic [RES_BITS-1:0]  rx;

  logic [DIV_W-1:0]     req_half;
  logic [NB_W-1:0]      req_bits;
  logic [IDX_W-1:0]     nxt;
  logic                 take_bit;
  logic [RES_BITS-1:0]  rx_next;

  assign req_half = burst ? DIV_W'(HALF_MIN) :
                    (half_div < DIV_W'(HALF_MIN)) ? DIV_W'(HALF_MIN) :
                    (half_div > DIV_W'(HALF_MAX)) ? DIV_W'(HALF_MAX) : half_div;
  assign req_bits = (bit_count == '0 || bit_count > NB_W'(RES_BITS)) ? NB_W'(RES_BITS) : bit_count;
  assign nxt      = hidx + IDX_W'(1);
  assign take_bit = nxt[0] && (nxt >= IDX_W'(FIRST_SAMPLE));
  assign rx_next  = rx | (RES_BITS'(adc_dout) << bpos);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      adc_cs_n     <= 1'b1;
      adc_sclk     <= 1'b0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      sample_bits  <= '0;
      half_len     <= DIV_W'(HALF_MIN);
      cnt          <= '0;
      hidx         <= '0;
      end_idx      <= '0;
      bpos         <= '0;
      rx           <= '0;
    end else begin
      sample_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_FRAME;
            adc_cs_n <= 1'b0;
            half_len <= req_half;
            end_idx  <= IDX_W'(2*LEAD_FALLS + 1) + (IDX_W'(req_bits) << 1);
            sample_bits <= req_bits;
            cnt      <= {1'b0, req_half} - CNT_ONE;
            hidx     <= '0;
            bpos     <= BP_W'(RES_BITS - 1);
            rx       <= '0;
          end
        end
        ST_FRAME: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_ONE;
          end else begin
            cnt  <= {1'b0, half_len} - CNT_ONE;
            hidx <= nxt;
            if (take_bit) begin
              rx   <= rx_next;
              bpos <= bpos - BP_W'(1);
            end
            if (nxt == end_idx) begin
              state        <= ST_GAP;
              adc_cs_n     <= 1'b1;
              adc_sclk     <= 1'b0;
              sample_valid <= 1'b1;
              sample_data  <= rx_next;
              cnt          <= {half_len, 1'b0} - CNT_ONE;
            end else begin
              adc_sclk <= nxt[0];
            end
          end
        end
        ST_GAP: begin
          if (cnt != '0) cnt <= cnt - CNT_ONE;
          else           state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic             sclk_q, cs_q;
  logic [IDX_W-1:0] chk_rises;
  logic [CNT_W-1:0] chk_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      chk_rises <= '0;
      chk_hi    <= '0;
    end else begin
      sclk_q <= adc_sclk;
      cs_q   <= adc_cs_n;
      if (cs_q && !adc_cs_n)        chk_rises <= '0;
      else if (adc_sclk && !sclk_q) chk_rises <= chk_rises + IDX_W'(1);
      chk_hi <= adc_sclk ? chk_hi + CNT_ONE : '0;
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) adc_cs_n |-> !adc_sclk); // R7
  AST_CS_GUARD: assert property (@(posedge clk) disable iff (!rst_n) $rose(adc_sclk) |-> (!adc_cs_n && !$past(adc_cs_n))); // R8
  AST_SCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(adc_sclk) |-> (chk_hi >= CNT_W'(HALF_MIN) && chk_hi <= CNT_W'(HALF_MAX))); // R9
  AST_RISE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |-> (chk_rises == IDX_W'(LEAD_FALLS) + IDX_W'(sample_bits))); // R1
  AST_BITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |-> (sample_bits != '0 && sample_bits <= NB_W'(RES_BITS))); // R5
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |-> ((sample_data & ({RES_BITS{1'b1}} >> sample_bits)) == '0)); // R6
  AST_FRAME_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !adc_cs_n |-> busy); // R10
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |-> $rose(adc_cs_n)); // R11
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sample_valid |=> !sample_valid); // R11

endmodule

// File: tb/serial_adc_reader_tb.sv
`timescale 1ns/1ps
module serial_adc_reader_tb_top;
  localparam int H_MIN = 16;
  localparam int H_MAX = 39;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        burst = 1'b0;
  logic [7:0]  half_div = 8'd16;
  logic [3:0]  bit_count = 4'd12;
  logic        adc_dout = 1'b0;
  logic        adc_cs_n, adc_sclk, busy, sample_valid;
  logic [11:0] sample_data;
  logic [3:0]  sample_bits;

  int checks = 0;
  int errors = 0;
  int idle_bad = 0;

  always #2 clk = ~clk;

  serial_adc_reader #(.CLK_HZ(250_000_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .burst(burst), .half_div(half_div),
    .bit_count(bit_count), .adc_dout(adc_dout), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .busy(busy), .sample_valid(sample_valid), .sample_data(sample_data), .sample_bits(sample_bits));

  // converter model: toggles during acquisition, then MSB-first after 5th fall
  logic [11:0] mdl_code = 12'h000;
  int fcnt = 0;
  always @(negedge adc_cs_n) begin fcnt = 0; adc_dout = 1'b1; end
  always @(negedge adc_sclk) if (!adc_cs_n) begin
    fcnt = fcnt + 1;
    if (fcnt >= 5 && fcnt <= 16) begin
      int idx;
      idx = 16 - fcnt;
      adc_dout = mdl_code[idx];
    end else adc_dout = ~adc_dout;
  end

  always @(negedge clk) if (rst_n && adc_cs_n && adc_sclk) idle_bad++;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [11:0] code, input int n_in, input int div_in,
                           input bit bst, input bit poke, input bit gap);
    int en, eh, cyc, rises, first_rise, hi_w, g, sgn;
    logic [11:0] exp;
    bit stayed;
    en = (n_in == 0 || n_in > 12) ? 12 : n_in;
    eh = bst ? H_MIN : (div_in < H_MIN ? H_MIN : (div_in > H_MAX ? H_MAX : div_in));
    exp = code & ~(12'hFFF >> en);
    while (busy) @(negedge clk);
    mdl_code = code; bit_count = 4'(n_in); half_div = 8'(div_in); burst = bst;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(adc_cs_n == 1'b0 && adc_sclk == 1'b0, "R8", "cs low, sclk idle at start", int'(adc_cs_n), 0);
    cyc = 0; rises = 0; first_rise = -1; hi_w = 0;
    while (!sample_valid && cyc < 5000) begin
      logic prev;
      prev = adc_sclk;
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) begin start = 1'b1; bit_count = 4'd3; half_div = 8'd39; burst = ~bst; end
      if (poke && cyc == 41) start = 1'b0;
      if (adc_sclk && !prev) begin rises++; if (first_rise < 0) first_rise = cyc; end
      if (adc_sclk && rises == 1) hi_w++;
    end
    check(cyc == (9 + 2*en)*eh, en == 12 ? "R1" : "R5", "cs low cycles", cyc, (9 + 2*en)*eh);
    check(rises == 4 + en, "R1", "sclk rising edges", rises, 4 + en);
    check(first_rise == eh, "R8", "cs fall to first rise", first_rise, eh);
    check(hi_w == eh, "R9", "sclk high width", hi_w, eh);
    check(sample_data == exp, "R2", "sample data (acquisition noise R3)", int'(sample_data), int'(exp));
    check(sample_bits == 4'(en), "R6", "sample bits", int'(sample_bits), en);
    check(adc_cs_n == 1'b1, "R11", "cs high with valid", int'(adc_cs_n), 1);
    if (en == 12) begin
      sgn = (code >= 12'h800) ? int'(code) - 4096 : int'(code);
      check($signed(sample_data) == sgn, "R4", "signed value", int'($signed(sample_data)), sgn);
    end
    @(negedge clk);
    check(sample_valid == 1'b0, "R11", "valid one cycle", int'(sample_valid), 0);
    if (poke) begin
      stayed = 1'b1;
      for (int i = 0; i < 2*eh + 6; i++) begin
        if (!adc_cs_n || sample_valid) stayed = 1'b0;
        @(negedge clk);
      end
      check(stayed && !busy, "R10", "start while busy ignored", int'(stayed), 1);
    end
    if (gap) begin
      start = 1'b1;
      g = 1;
      while (adc_cs_n && g < 3000) begin @(negedge clk); g++; end
      start = 1'b0;
      check(g == 2*eh + 1, "R12", "cs high between frames", g, 2*eh + 1);
      while (!sample_valid) @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] codes [6];
    codes[0] = 12'h7FF; codes[1] = 12'h800; codes[2] = 12'hFFF;
    codes[3] = 12'h001; codes[4] = 12'h000; codes[5] = 12'hA5C;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(adc_cs_n == 1'b1 && adc_sclk == 1'b0 && !busy && !sample_valid && sample_data == '0,
          "R7", "reset state", int'(adc_cs_n), 1);
    // R5 R6 sweep every bit count over several codes
    for (int n = 0; n < 16; n++)
      for (int c = 0; c < 6; c++)
        run_frame(codes[c], n, H_MIN, 1'b0, 1'b0, 1'b0);
    // R9 divider clamp and burst
    run_frame(12'h3C5, 12, 5, 1'b0, 1'b0, 1'b0);
    run_frame(12'h3C5, 12, 27, 1'b0, 1'b0, 1'b0);
    run_frame(12'h3C5, 7, 39, 1'b0, 1'b0, 1'b0);
    run_frame(12'h3C5, 12, 60, 1'b0, 1'b0, 1'b0);
    run_frame(12'h3C5, 12, 30, 1'b1, 1'b0, 1'b0);
    // R10 start while busy, R12 inter-frame gap
    run_frame(12'h96A, 9, 22, 1'b0, 1'b1, 1'b0);
    run_frame(12'h5A5, 12, 20, 1'b0, 1'b0, 1'b1);
    run_frame(12'h5A5, 4, 5, 1'b1, 1'b0, 1'b1);
    check(idle_bad == 0, "R7", "sclk high while cs high", idle_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule